// File: doc/BRIEF.md
# Forward-Difference Deflection Waveform Generator

This block produces one deflection sample per video line over a field. A host writes start values once. At each field start they are copied into a cascade of accumulators. Each line strobe then advances the cascade one step, so the lowest accumulator traces a polynomial in (x−0.5) across the field with no multiplier in the loop. A mode input, captured at field start, picks one of two waveforms:

- a cubic shape for the vertical sweep, which uses four active accumulators;
- a quartic shape for the East/West correction, which uses all five.

Before the sample leaves the block, it is compensated for the average beam current. In vertical mode the centred waveform is scaled by a gain that rises with beam current. In East/West mode an offset proportional to beam current is added. The result is saturated into an unsigned 15-bit code for a downstream PWM stage.

Top module: `defl_poly_gen`

## Requirements
- R1: After reset, `sample` reads 16384 (mid-scale) and all five start-value registers hold zero.
- R2: A cycle with `wr_en` high and `wr_sel` in 0..4 stores `wr_data` as signed 12-bit start value d[wr_sel]. A value of `wr_sel` in 5..7 changes no register.
- R3: On `field_start`, accumulator i is loaded with d[i] sign-extended and multiplied by 8. In vertical mode the fifth accumulator is loaded with zero instead. A write takes effect only at the next field start; a write in the same cycle as a field start applies from the field after it.
- R4: On `line_stb`, each accumulator adds the pre-step value of the accumulator one order above it, and the highest stays unchanged. After n strobes the centre value is c = Σ C(n,k)·8·d[k]. When `field_start` and `line_stb` arrive together, the load wins and n = 0.
- R5: `mode` (0 = vertical, 1 = East/West) is captured at field start. Changes during a field affect neither the chain nor the compensation until the next field start.
- R6: In vertical mode, `sample` = floor(c·(1024 + beam_avg)/1024) + 16384, so a zero beam gives the unscaled waveform.
- R7: In East/West mode, `sample` = c + 4·beam_avg + 16384, so a zero beam gives no shift.
- R8: The compensated value saturates to 0..32767 and never wraps.
- R9: `sample` is registered. It shows the accumulator state one clock after that state changes, compensated with the `beam_avg` present in the clock that loads it.
- R10: With neither strobe asserted, the accumulators hold their values and `sample` stays constant for a constant `beam_avg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | One-cycle strobe: reload the accumulators and capture the mode |
| line_stb | input | 1 | One-cycle strobe: advance the waveform by one line |
| mode | input | 1 | 0 = vertical cubic, 1 = East/West quartic |
| wr_en | input | 1 | Host write enable for a start value |
| wr_sel | input | 3 | Start-value index, 0..4 valid |
| wr_data | input | 12 | Signed start value |
| beam_avg | input | 8 | Average beam current, unsigned |
| sample | output | 15 | Compensated unsigned waveform sample |

## Verification
The bench uses the default parameters:
- 12-bit start values;
- 24-bit accumulators;
- a load shift of 3;
- a gain fraction of 10 bits;
- an offset shift of 2.

Random fields of up to 40 lines use bounded high-order coefficients. This keeps every accumulator inside 24 bits, so a closed-form binomial model predicts each sample exactly. At the same time, large low-order terms drive the output into both saturation limits. Directed fields cover invalid indices, writes and mode changes during a field, coinciding strobes, idle holding, and the full beam range in both modes.

// File: rtl/defl_pkg.sv
package defl_pkg;
  typedef enum logic {
    MODE_VERT = 1'b0,
    MODE_EW   = 1'b1
  } defl_mode_e;
endpackage

// File: rtl/defl_coef_bank.sv
module defl_coef_bank #(
  parameter int N_COEF = 5,
  parameter int COEF_W = 12,
  parameter int SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [COEF_W-1:0]             wr_data,
  output logic [N_COEF-1:0][COEF_W-1:0] coef_q
);
  logic [N_COEF-1:0][COEF_W-1:0] coef_d;

  always_comb begin
    coef_d = coef_q;
    for (int i = 0; i < N_COEF; i++) begin
      if (wr_en && (wr_sel == SEL_W'(i))) coef_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= '0;
    else        coef_q <= coef_d;
  end

  // R2: an out-of-range index leaves every start value untouched
  p_bad_sel_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel >= SEL_W'(N_COEF))) |=> $stable(coef_q));
endmodule

// File: rtl/defl_acc_chain.sv
module defl_acc_chain #(
  parameter int N_ACC   = 5,
  parameter int COEF_W  = 12,
  parameter int ACC_W   = 24,
  parameter int LOAD_SH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         step,
  input  logic                         ew_mode,
  input  logic [N_ACC-1:0][COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]      center
);
  localparam int EXT_W = ACC_W - COEF_W;

  logic signed [ACC_W-1:0] acc_q  [N_ACC];
  logic signed [ACC_W-1:0] acc_d  [N_ACC];
  logic signed [ACC_W-1:0] load_v [N_ACC];
  logic signed [ACC_W-1:0] nbr    [N_ACC];

  for (genvar g = 0; g < N_ACC; g++) begin : g_stage
    logic signed [ACC_W-1:0] ext;
    assign ext = {{EXT_W{coef[g][COEF_W-1]}}, coef[g]};
    if (g == N_ACC-1) begin : g_top
      // highest order only exists in the quartic mode
      assign load_v[g] = ew_mode ? (ext <<< LOAD_SH) : '0;
      assign nbr[g]    = '0;
    end else begin : g_low
      assign load_v[g] = ext <<< LOAD_SH;
      assign nbr[g]    = acc_q[g+1];
    end

    // R10: no strobe, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(acc_q[g]));
  end

  always_comb begin
    for (int i = 0; i < N_ACC; i++) begin
      acc_d[i] = acc_q[i];
      if (load)      acc_d[i] = load_v[i];
      else if (step) acc_d[i] = acc_q[i] + nbr[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= acc_d[i];
    end
  end

  assign center = acc_q[0];

  // R4: the highest order term never moves inside a field
  p_top_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(acc_q[N_ACC-1]));
  // R3: vertical load clears the quartic term
  p_vert_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ew_mode) |=> (acc_q[N_ACC-1] == '0));
endmodule

// File: rtl/defl_beam_comp.sv
module defl_beam_comp #(
  parameter int ACC_W     = 24,
  parameter int BEAM_W    = 8,
  parameter int GAIN_FRAC = 10,
  parameter int OFF_SH    = 2,
  parameter int OUT_W     = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ew_mode,
  input  logic [BEAM_W-1:0]       beam,
  input  logic signed [ACC_W-1:0] center,
  output logic [OUT_W-1:0]        sample_q
);
  localparam int GAIN_W = ((GAIN_FRAC > BEAM_W) ? GAIN_FRAC : BEAM_W) + 2;
  localparam int PROD_W = ACC_W + GAIN_W + OFF_SH + 1;
  localparam logic signed [PROD_W-1:0] MID_X = PROD_W'(2**(OUT_W-1));
  localparam logic signed [PROD_W-1:0] MAX_X = PROD_W'(2**OUT_W - 1);
  localparam logic signed [ACC_W-1:0]  MID_A = ACC_W'(2**(OUT_W-1));
  localparam logic [OUT_W-1:0]         MID_O = OUT_W'(2**(OUT_W-1));

  logic [GAIN_W-1:0]        gain;
  logic signed [PROD_W-1:0] center_x, gain_x, off_x, prod, scaled, sum;
  logic [OUT_W-1:0]         sample_d;

  always_comb begin
    gain     = GAIN_W'(2**GAIN_FRAC) + GAIN_W'(beam);
    center_x = {{(PROD_W-ACC_W){center[ACC_W-1]}}, center};
    gain_x   = {{(PROD_W-GAIN_W){1'b0}}, gain};
    off_x    = {{(PROD_W-BEAM_W){1'b0}}, beam} <<< OFF_SH;
    prod     = center_x * gain_x;
    scaled   = prod >>> GAIN_FRAC;
    sum      = (ew_mode ? (center_x + off_x) : scaled) + MID_X;
    if (sum < 0)          sample_d = '0;
    else if (sum > MAX_X) sample_d = '1;
    else                  sample_d = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= MID_O;
    else        sample_q <= sample_d;
  end

  // R6: zero beam leaves a negative in-range vertical value unscaled
  p_vert_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ew_mode && beam == '0 && center < 0 && center >= -MID_A)
    |=> (sample_q == {1'b0, $past(center[OUT_W-2:0])}));
  // R7: zero beam gives no East/West shift
  p_ew_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ew_mode && beam == '0 && center >= 0 && center < MID_A)
    |=> (sample_q == {1'b1, $past(center[OUT_W-2:0])}));
  // R8: out-of-range vertical values clamp to the rails
  p_sat_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ew_mode && center >= MID_A) |=> (sample_q == '1));
  p_sat_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ew_mode && center < -MID_A) |=> (sample_q == '0));
endmodule

// File: rtl/defl_poly_gen.sv
module defl_poly_gen #(
  parameter int N_COEF    = 5,
  parameter int COEF_W    = 12,
  parameter int SEL_W     = 3,
  parameter int ACC_W     = 24,
  parameter int LOAD_SH   = 3,
  parameter int BEAM_W    = 8,
  parameter int GAIN_FRAC = 10,
  parameter int OFF_SH    = 2,
  parameter int OUT_W     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              line_stb,
  input  logic              mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [BEAM_W-1:0] beam_avg,
  output logic [OUT_W-1:0]  sample
);
  import defl_pkg::*;

  logic [N_COEF-1:0][COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]       center;
  defl_mode_e                    mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (field_start) mode_d = defl_mode_e'(mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_VERT;
    else        mode_q <= mode_d;
  end

  defl_coef_bank #(.N_COEF(N_COEF), .COEF_W(COEF_W), .SEL_W(SEL_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .coef_q(coef)
  );

  defl_acc_chain #(.N_ACC(N_COEF), .COEF_W(COEF_W), .ACC_W(ACC_W),
                   .LOAD_SH(LOAD_SH)) i_chain (
    .clk(clk), .rst_n(rst_n), .load(field_start), .step(line_stb),
    .ew_mode(mode), .coef(coef), .center(center)
  );

  defl_beam_comp #(.ACC_W(ACC_W), .BEAM_W(BEAM_W), .GAIN_FRAC(GAIN_FRAC),
                   .OFF_SH(OFF_SH), .OUT_W(OUT_W)) i_comp (
    .clk(clk), .rst_n(rst_n), .ew_mode(mode_q == MODE_EW), .beam(beam_avg),
    .center(center), .sample_q(sample)
  );

  // R5: the captured mode only moves at a field start
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(mode_q));
endmodule

// File: tb/test_defl_poly_gen.sv
module test_defl_poly_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, field_start, line_stb, mode, wr_en;
  logic [2:0]  wr_sel;
  logic [11:0] wr_data;
  logic [7:0]  beam_avg;
  logic [14:0] sample;

  int     n_chk = 0, n_err = 0;
  int     sh[5];
  longint d[5];
  int     n_line;
  bit     cur_ew;

  always #(CLK_PERIOD/2) clk = ~clk;

  defl_poly_gen i_defl_poly_gen (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_stb(line_stb),
    .mode(mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .beam_avg(beam_avg), .sample(sample)
  );

  function automatic longint binom(int n, int k);
    longint r = 1;
    if (k > n) return 0;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  function automatic int exp_out(int beam);
    longint c = 0, v;
    for (int k = 0; k < 5; k++) c += binom(n_line, k) * d[k];
    if (cur_ew) v = c + 4 * beam + 16384;
    else        v = ((c * (1024 + beam)) >>> 10) + 16384;
    if (v < 0) v = 0;
    if (v > 32767) v = 32767;
    return int'(v);
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check_val(string req, int expv);
    n_chk++;
    if (int'(sample) != expv) begin
      n_err++;
      $display("FAIL %s: sample=%0d expected=%0d (line %0d)", req, sample, expv, n_line);
    end
  endtask

  task automatic check(string req);
    cyc();
    check_val(req, exp_out(int'(beam_avg)));
  endtask

  task automatic wr(int sel, int val);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 12'(val);
    cyc();
    wr_en = 1'b0;
    if (sel < 5) sh[sel] = val;
  endtask

  task automatic latch_model();
    cur_ew = mode;
    for (int k = 0; k < 5; k++) d[k] = longint'(sh[k]) * 8;
    if (!cur_ew) d[4] = 0;
    n_line = 0;
  endtask

  task automatic field(bit m);
    mode = m; field_start = 1'b1;
    cyc();
    field_start = 1'b0;
    latch_model();
  endtask

  task automatic step();
    line_stb = 1'b1;
    cyc();
    line_stb = 1'b0;
    n_line++;
  endtask

  function automatic int rs(int b);
    return int'($urandom_range(2 * b)) - b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: sample=%0d expected=finish", sample);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; field_start = 0; line_stb = 0; mode = 0; wr_en = 0;
    wr_sel = 0; wr_data = 0; beam_avg = 0;
    for (int k = 0; k < 5; k++) begin sh[k] = 0; d[k] = 0; end
    n_line = 0; cur_ew = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    check_val("R1 reset sample", 16384);

    // R1: zero start values after reset, quartic mode, any beam shift only
    field(1'b1);
    check("R1 zero start values");
    step(); step();
    check("R1 zero start values stepped");

    // R2: invalid indices change nothing
    wr(5, 100); wr(6, -77); wr(7, 2047);
    field(1'b1);
    check("R2 invalid index ignored");
    wr(1, 300); wr(0, -1000);
    field(1'b0);
    check("R2 valid write");
    step();
    check("R2 valid write stepped");

    // R3: vertical mode ignores a4
    wr(4, 5); wr(3, 2); wr(2, -30); wr(1, 40); wr(0, 100);
    field(1'b0);
    for (int i = 0; i < 10; i++) begin step(); check("R3 vertical a4 forced zero"); end
    field(1'b1);
    for (int i = 0; i < 10; i++) begin step(); check("R4 quartic chain"); end

    // R3 + R5: writes and mode change inside a field wait for the next start
    wr(0, -2000); wr(2, 150); mode = 1'b0;
    for (int i = 0; i < 5; i++) begin step(); check("R3 R5 mid-field change deferred"); end
    field(1'b0);
    for (int i = 0; i < 5; i++) begin step(); check("R3 new values at field start"); end

    // R10: hold without strobes
    beam_avg = 8'd37;
    check("R10 idle hold a");
    cyc(); cyc();
    check("R10 idle hold b");

    // R4: coinciding strobes, load wins
    mode = 1'b1; field_start = 1'b1; line_stb = 1'b1;
    cyc();
    field_start = 1'b0; line_stb = 1'b0;
    latch_model();
    check("R4 field start beats line strobe");

    // R3: write in the field-start cycle applies only to the next field
    mode = 1'b1; field_start = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'(1500);
    cyc();
    field_start = 1'b0; wr_en = 1'b0;
    latch_model();
    sh[0] = 1500;
    check("R3 write with field start deferred");
    field(1'b1);
    check("R3 deferred write now active");

    // R6 / R7 / R8: beam extremes and saturation
    wr(4, 0); wr(3, 0); wr(2, 0); wr(1, 2047); wr(0, 2047);
    field(1'b0);
    beam_avg = 8'd255;
    check("R6 max gain");
    step();
    check("R8 saturate high");
    wr(1, -2048); wr(0, -2048);
    field(1'b1);
    beam_avg = 8'd0;
    step();
    check("R8 saturate low");
    wr(1, 0); wr(0, 1000);
    field(1'b1);
    beam_avg = 8'd255;
    check("R7 max offset");
    field(1'b0);
    beam_avg = 8'd0;
    check("R6 unity gain");

    // R9: beam taken each cycle by the output register
    beam_avg = 8'd200;
    check("R9 beam change seen next cycle");

    // random fields
    for (int f = 0; f < 14; f++) begin
      wr(4, rs(3)); wr(3, rs(20)); wr(2, rs(200)); wr(1, rs(2047)); wr(0, rs(2047));
      field(1'($urandom_range(1)));
      beam_avg = 8'($urandom_range(255));
      check(cur_ew ? "R7 random field start" : "R6 random field start");
      for (int l = 0; l < 40; l++) begin
        beam_avg = 8'($urandom_range(255));
        if ($urandom_range(3) == 0) mode = ~mode;
        step();
        check(cur_ew ? "R7 R8 random line" : "R6 R8 random line");
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule